// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Datapath

This block is an in-order, five-stage processor datapath (fetch, decode, execute, memory access, writeback) for a small 32-bit load/store instruction subset. The subset is word load, add, subtract, bitwise AND, bitwise OR and branch-on-equal. The instruction store, the data store, a 32-entry register bank, the main decoder and the ALU function select are all inside the block. Control signals are produced once in decode. They then travel down the pipeline as three packed groups: execute, memory and writeback. Each stage strips off the group it consumes.

The block has no forwarding, no hazard detection and no stall logic. Programs must place enough independent instructions between a producer and its consumer, and they must tolerate the instructions that follow a branch. The program is supplied as a parameter image. A set of observation outputs shows the PC and the contents of every pipeline register each cycle, so a bench can follow instructions stage by stage. On reset, register n holds 10+n and each data word holds 1000 plus its byte address, so programs have known operands without any loading phase.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, the PC reads 500 and every pipeline register and control group reads zero. The reset contents are: register n holds 10+n, and the data word at byte address a holds 1000+a.
- R2: Each cycle without a taken branch, the PC advances by 4. The fetch stage holds the word with index (PC-500)/4 from `PROG_IMAGE`, where word k occupies bits [32k+31:32k]. A PC outside the image fetches zero.
- R3: The opcode sits in bits 31:26, with 0x00 for register-register, 0x23 for load and 0x04 for branch-on-equal. `dbg_idex_ctrl` is laid out, MSB first, as RegWrite, MemToReg, Branch, MemRead, MemWrite, RegDest, ALUOp1, ALUOp0, ALUSrc. The encodings are 9'b10_000_1100 for register-register, 9'b11_010_0001 for load, 9'b00_100_0010 for branch, and all zero for any other opcode.
- R4: Bits 15:0 are sign-extended to 32 bits. When ALUSrc is 1, this value replaces the second register operand at the ALU.
- R5: ALUOp 00 adds and ALUOp 01 subtracts. ALUOp 10 uses the function field in bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR.
- R6: A load reads the data word selected by bits [31:2] of its computed address. The data store reads without a clock.
- R7: The destination is the field in bits 15:11 when RegDest is 1, and the field in bits 20:16 otherwise. The value written is the loaded word when MemToReg is 1, and the ALU result otherwise.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: A value being written in writeback is returned to a decode-stage read of the same register in the same cycle. A consumer placed three instructions after its producer therefore sees the new value.
- R10: The branch target is PC+4 plus the sign-extended offset shifted left by 2. When the branch instruction is in the memory stage with Branch=1 and the ALU zero flag set, the PC takes the target on the next edge. The three instructions after the branch still complete.
- R11: The control groups pass down unchanged. The execute-to-memory register carries the previous cycle's writeback and memory groups, and the memory-to-writeback register carries the previous cycle's writeback group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Program counter |
| dbg_ifid_instr | output | 32 | Fetched instruction held for decode |
| dbg_ifid_pc4 | output | 32 | PC+4 held for decode |
| dbg_idex_ctrl | output | 9 | Packed WB/M/EX control groups in the execute stage |
| dbg_idex_rda | output | 32 | First register operand in the execute stage |
| dbg_idex_rdb | output | 32 | Second register operand in the execute stage |
| dbg_idex_imm | output | 32 | Sign-extended immediate in the execute stage |
| dbg_exmem_ctrl | output | 5 | Packed WB/M control groups in the memory stage |
| dbg_exmem_alu | output | 32 | ALU result in the memory stage |
| dbg_exmem_zero | output | 1 | ALU zero flag in the memory stage |
| dbg_exmem_target | output | 32 | Branch target in the memory stage |
| dbg_memwb_ctrl | output | 2 | WB control group (RegWrite, MemToReg) in writeback |
| dbg_memwb_wreg | output | 5 | Destination register in writeback |
| dbg_wb_value | output | 32 | Value selected for writeback |

## Verification
The bench overrides `IMEM_WORDS` to 32 and supplies a 17-instruction `PROG_IMAGE`. `RESET_PC` stays at 500 and `DMEM_WORDS` stays at 64. With 32 image words, the PC runs past the end of the program and then past the end of the image within the run, so zero fetches are observed. The program exercises every ALU function and an unaligned load address. It also includes a negative load offset, a consumer exactly three slots behind its producer, a write to register 0, and a taken branch followed by a not-taken branch inside its shadow. The 64-word data store covers every address the program touches.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN  = 32;
    localparam int RA_W  = 5;

    localparam logic [5:0] OPC_ALU  = 6'h00;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_BEQ  = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    // Execute group, MSB first: RegDest, ALUOp[1:0], ALUSrc
    typedef struct packed {
        logic       reg_dest;
        logic [1:0] alu_op;
        logic       alu_src;
    } ex_bits_t;

    // Memory group, MSB first: Branch, MemRead, MemWrite
    typedef struct packed {
        logic branch;
        logic mem_read;
        logic mem_write;
    } mem_bits_t;

    // Writeback group, MSB first: RegWrite, MemToReg
    typedef struct packed {
        logic reg_write;
        logic mem_to_reg;
    } wb_bits_t;

    typedef struct packed {
        wb_bits_t  wb;
        mem_bits_t mem;
        ex_bits_t  ex;
    } ctl_bundle_t;

    localparam ctl_bundle_t CTL_BUBBLE = 9'b00_000_0000;
    localparam ctl_bundle_t CTL_RTYPE  = 9'b10_000_1100;
    localparam ctl_bundle_t CTL_LOAD   = 9'b11_010_0001;
    localparam ctl_bundle_t CTL_BEQ    = 9'b00_100_0010;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_fn_e;

    typedef struct packed {
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] instr;
    } ifid_t;

    typedef struct packed {
        ctl_bundle_t     ctl;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] rda;
        logic [XLEN-1:0] rdb;
        logic [XLEN-1:0] imm;
        logic [RA_W-1:0] rt;
        logic [RA_W-1:0] rd;
    } idex_t;

    typedef struct packed {
        wb_bits_t        wb;
        mem_bits_t       mem;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] rdb;
        logic            zero;
        logic [RA_W-1:0] wreg;
    } exmem_t;

    typedef struct packed {
        wb_bits_t        wb;
        logic [XLEN-1:0] rdata;
        logic [XLEN-1:0] alu;
        logic [RA_W-1:0] wreg;
    } memwb_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [5:0]  opcode,
    output ctl_bundle_t ctl
);

    always_comb begin
        unique case (opcode)
            OPC_ALU:  ctl = CTL_RTYPE;
            OPC_LOAD: ctl = CTL_LOAD;
            OPC_BEQ:  ctl = CTL_BEQ;
            default:  ctl = CTL_BUBBLE;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        alu_op,
    input  logic [5:0]        funct,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic              zero
);

    alu_fn_e fn;

    always_comb begin
        unique case (alu_op)
            2'b00:   fn = ALU_ADD;
            2'b01:   fn = ALU_SUB;
            default: begin
                unique case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    default: fn = ALU_ADD;
                endcase
            end
        endcase
    end

    always_comb begin
        unique case (fn)
            ALU_ADD: result = op_a + op_b;
            ALU_SUB: result = op_a - op_b;
            ALU_AND: result = op_a & op_b;
            ALU_OR:  result = op_a | op_b;
            default: result = '0;
        endcase
    end

    assign zero = (result == '0);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int SEED   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] rb,
    output logic [DATA_W-1:0] rda,
    output logic [DATA_W-1:0] rdb,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < DEPTH; n++) begin
                regs[n] <= DATA_W'(SEED + n);
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Register 0 first, then same-cycle writeback, then stored value
    assign rda = (ra == '0) ? '0 : ((we && (wa == ra)) ? wd : regs[ra]);
    assign rdb = (rb == '0) ? '0 : ((we && (wa == rb)) ? wd : regs[rb]);

endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem #(
    parameter int WORDS    = 64,
    parameter int DATA_W   = 32,
    parameter int BASE_VAL = 1000,
    localparam int AW      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     word_idx,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= DATA_W'(BASE_VAL + 4 * i);
            end
        end else if (wr_en) begin
            mem[word_idx] <= wdata;
        end
    end

    assign rdata = rd_en ? mem[word_idx] : '0;

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int                      IMEM_WORDS = 32,
    parameter logic [31:0]             RESET_PC   = 32'd500,
    parameter logic [IMEM_WORDS*32-1:0] PROG_IMAGE = '0,
    parameter int                      DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] dbg_pc,
    output logic [31:0] dbg_ifid_instr,
    output logic [31:0] dbg_ifid_pc4,
    output logic [8:0]  dbg_idex_ctrl,
    output logic [31:0] dbg_idex_rda,
    output logic [31:0] dbg_idex_rdb,
    output logic [31:0] dbg_idex_imm,
    output logic [4:0]  dbg_exmem_ctrl,
    output logic [31:0] dbg_exmem_alu,
    output logic        dbg_exmem_zero,
    output logic [31:0] dbg_exmem_target,
    output logic [1:0]  dbg_memwb_ctrl,
    output logic [4:0]  dbg_memwb_wreg,
    output logic [31:0] dbg_wb_value
);

    localparam int IW = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;
    localparam int DW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] pc;
    ifid_t           ifid;
    idex_t           idex;
    exmem_t          exmem;
    memwb_t          memwb;

    // ---------------- fetch ----------------
    logic [XLEN-1:0] fetch_off;
    logic [XLEN-1:0] fetch_word;
    logic [XLEN-1:0] instr_f;
    logic [XLEN-1:0] pc_plus4;
    logic            take_branch;
    logic [XLEN-1:0] pc_next;

    always_comb begin
        fetch_off  = pc - RESET_PC;
        fetch_word = fetch_off >> 2;
        if (fetch_word < 32'(IMEM_WORDS)) begin
            instr_f = PROG_IMAGE[{fetch_word[IW-1:0], 5'd0} +: 32];
        end else begin
            instr_f = '0;
        end
    end

    assign pc_plus4    = pc + 32'd4;
    assign take_branch = exmem.mem.branch & exmem.zero;
    assign pc_next     = take_branch ? exmem.target : pc_plus4;

    // ---------------- decode ----------------
    ctl_bundle_t     ctl_d;
    logic [XLEN-1:0] rda_d;
    logic [XLEN-1:0] rdb_d;
    logic [XLEN-1:0] imm_d;
    logic            wb_we;
    logic [XLEN-1:0] wb_value;

    pipe5_decode u_decode (
        .opcode (ifid.instr[31:26]),
        .ctl    (ctl_d)
    );

    pipe5_regfile #(
        .ADDR_W (RA_W),
        .DATA_W (XLEN),
        .SEED   (10)
    ) u_regs (
        .clk (clk),
        .rst (rst),
        .ra  (ifid.instr[25:21]),
        .rb  (ifid.instr[20:16]),
        .rda (rda_d),
        .rdb (rdb_d),
        .we  (wb_we),
        .wa  (memwb.wreg),
        .wd  (wb_value)
    );

    assign imm_d = {{16{ifid.instr[15]}}, ifid.instr[15:0]};

    // ---------------- execute ----------------
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_zero;
    logic [XLEN-1:0] target_e;
    logic [RA_W-1:0] wreg_e;

    assign alu_b    = idex.ctl.ex.alu_src ? idex.imm : idex.rdb;
    assign target_e = idex.pc4 + (idex.imm << 2);
    assign wreg_e   = idex.ctl.ex.reg_dest ? idex.rd : idex.rt;

    pipe5_alu #(
        .DATA_W (XLEN)
    ) u_alu (
        .alu_op (idex.ctl.ex.alu_op),
        .funct  (idex.imm[5:0]),
        .op_a   (idex.rda),
        .op_b   (alu_b),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // ---------------- memory ----------------
    logic [XLEN-1:0] rdata_m;

    pipe5_dmem #(
        .WORDS    (DMEM_WORDS),
        .DATA_W   (XLEN),
        .BASE_VAL (1000)
    ) u_dmem (
        .clk      (clk),
        .rst      (rst),
        .word_idx (exmem.alu[DW+1:2]),
        .rd_en    (exmem.mem.mem_read),
        .wr_en    (exmem.mem.mem_write),
        .wdata    (exmem.rdb),
        .rdata    (rdata_m)
    );

    // ---------------- writeback ----------------
    assign wb_we    = memwb.wb.reg_write;
    assign wb_value = memwb.wb.mem_to_reg ? memwb.rdata : memwb.alu;

    // ---------------- stage registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= RESET_PC;
            ifid  <= '0;
            idex  <= '0;
            exmem <= '0;
            memwb <= '0;
        end else begin
            pc          <= pc_next;

            ifid.pc4    <= pc_plus4;
            ifid.instr  <= instr_f;

            idex.ctl    <= ctl_d;
            idex.pc4    <= ifid.pc4;
            idex.rda    <= rda_d;
            idex.rdb    <= rdb_d;
            idex.imm    <= imm_d;
            idex.rt     <= ifid.instr[20:16];
            idex.rd     <= ifid.instr[15:11];

            exmem.wb     <= idex.ctl.wb;
            exmem.mem    <= idex.ctl.mem;
            exmem.target <= target_e;
            exmem.alu    <= alu_res;
            exmem.rdb    <= idex.rdb;
            exmem.zero   <= alu_zero;
            exmem.wreg   <= wreg_e;

            memwb.wb    <= exmem.wb;
            memwb.rdata <= rdata_m;
            memwb.alu   <= exmem.alu;
            memwb.wreg  <= exmem.wreg;
        end
    end

    // ---------------- observation ----------------
    assign dbg_pc           = pc;
    assign dbg_ifid_instr   = ifid.instr;
    assign dbg_ifid_pc4     = ifid.pc4;
    assign dbg_idex_ctrl    = idex.ctl;
    assign dbg_idex_rda     = idex.rda;
    assign dbg_idex_rdb     = idex.rdb;
    assign dbg_idex_imm     = idex.imm;
    assign dbg_exmem_ctrl   = {exmem.wb, exmem.mem};
    assign dbg_exmem_alu    = exmem.alu;
    assign dbg_exmem_zero   = exmem.zero;
    assign dbg_exmem_target = exmem.target;
    assign dbg_memwb_ctrl   = memwb.wb;
    assign dbg_memwb_wreg   = memwb.wreg;
    assign dbg_wb_value     = wb_value;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] ifid_instr,
    input logic [8:0]  idex_ctrl,
    input logic [31:0] idex_rda,
    input logic [4:0]  exmem_ctrl,
    input logic        exmem_zero,
    input logic [31:0] exmem_target,
    input logic [1:0]  memwb_ctrl
);

    // R2: sequential fetch when no branch resolves taken
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !(exmem_ctrl[2] && exmem_zero) |=> pc == $past(pc) + 32'd4);

    // R10: a resolved taken branch redirects the PC on the next edge
    a_r10_pc_branch: assert property (@(posedge clk) disable iff (rst)
        (exmem_ctrl[2] && exmem_zero) |=> pc == $past(exmem_target));

    // R8: a source field naming register 0 yields zero in execute
    a_r8_r0_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (ifid_instr[25:21] == 5'd0) |=> idex_rda == 32'd0);

    // R3: only the four defined control encodings reach execute
    a_r3_bundle_legal: assert property (@(posedge clk) disable iff (rst)
        (idex_ctrl == 9'b00_000_0000) || (idex_ctrl == 9'b10_000_1100) ||
        (idex_ctrl == 9'b11_010_0001) || (idex_ctrl == 9'b00_100_0010));

    // R11: WB/M groups move from execute to memory stage unchanged
    a_r11_exmem_shift: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> exmem_ctrl == $past(idex_ctrl[8:4]));

    // R11: WB group moves from memory to writeback stage unchanged
    a_r11_memwb_shift: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> memwb_ctrl == $past(exmem_ctrl[4:3]));

endmodule

bind pipe5_core pipe5_core_chk u_pipe5_core_chk (
    .clk          (clk),
    .rst          (rst),
    .pc           (dbg_pc),
    .ifid_instr   (dbg_ifid_instr),
    .idex_ctrl    (dbg_idex_ctrl),
    .idex_rda     (dbg_idex_rda),
    .exmem_ctrl   (dbg_exmem_ctrl),
    .exmem_zero   (dbg_exmem_zero),
    .exmem_target (dbg_exmem_target),
    .memwb_ctrl   (dbg_memwb_ctrl)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

    localparam int WORDS = 32;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [WORDS*32-1:0] build_image();
        logic [WORDS*32-1:0] img;
        img = '0;
        img[0*32  +: 32] = enc_i(6'h23, 1, 10, 16'd20);     // load r10 <- mem[r1+20]
        img[1*32  +: 32] = enc_r(2, 3, 11, 6'h22);          // r11 = r2 - r3
        img[2*32  +: 32] = enc_r(4, 5, 12, 6'h24);          // r12 = r4 & r5
        img[3*32  +: 32] = enc_r(6, 7, 13, 6'h25);          // r13 = r6 | r7
        img[4*32  +: 32] = enc_r(8, 9, 14, 6'h20);          // r14 = r8 + r9
        img[5*32  +: 32] = enc_r(10, 0, 15, 6'h20);         // r15 = r10 + r0
        img[6*32  +: 32] = enc_r(1, 1, 0, 6'h20);           // r0 = r1 + r1 (dropped)
        img[7*32  +: 32] = enc_r(14, 14, 16, 6'h20);        // r16 = r14 + r14 (3 behind)
        img[8*32  +: 32] = enc_r(12, 13, 18, 6'h20);        // r18 = r12 + r13
        img[9*32  +: 32] = enc_r(0, 1, 17, 6'h20);          // r17 = r0 + r1
        img[10*32 +: 32] = enc_i(6'h04, 1, 1, 16'd4);       // branch taken to 560
        img[11*32 +: 32] = enc_i(6'h04, 1, 2, 16'd8);       // branch not taken
        img[12*32 +: 32] = enc_r(9, 8, 22, 6'h22);          // r22 = r9 - r8
        img[13*32 +: 32] = enc_r(11, 7, 23, 6'h24);         // r23 = r11 & r7
        img[14*32 +: 32] = enc_r(1, 1, 25, 6'h20);          // skipped
        img[15*32 +: 32] = enc_r(1, 2, 21, 6'h20);          // r21 = r1 + r2
        img[16*32 +: 32] = enc_i(6'h23, 20, 19, 16'hFFFC);  // load r19 <- mem[r20-4]
        return img;
    endfunction

    localparam logic [WORDS*32-1:0] IMG = build_image();

    logic        clk;
    logic        rst;
    logic [31:0] dbg_pc, dbg_ifid_instr, dbg_ifid_pc4;
    logic [8:0]  dbg_idex_ctrl;
    logic [31:0] dbg_idex_rda, dbg_idex_rdb, dbg_idex_imm;
    logic [4:0]  dbg_exmem_ctrl;
    logic [31:0] dbg_exmem_alu;
    logic        dbg_exmem_zero;
    logic [31:0] dbg_exmem_target;
    logic [1:0]  dbg_memwb_ctrl;
    logic [4:0]  dbg_memwb_wreg;
    logic [31:0] dbg_wb_value;

    pipe5_core #(
        .IMEM_WORDS (WORDS),
        .RESET_PC   (32'd500),
        .PROG_IMAGE (IMG),
        .DMEM_WORDS (64)
    ) i_pipe5_core (
        .clk              (clk),
        .rst              (rst),
        .dbg_pc           (dbg_pc),
        .dbg_ifid_instr   (dbg_ifid_instr),
        .dbg_ifid_pc4     (dbg_ifid_pc4),
        .dbg_idex_ctrl    (dbg_idex_ctrl),
        .dbg_idex_rda     (dbg_idex_rda),
        .dbg_idex_rdb     (dbg_idex_rdb),
        .dbg_idex_imm     (dbg_idex_imm),
        .dbg_exmem_ctrl   (dbg_exmem_ctrl),
        .dbg_exmem_alu    (dbg_exmem_alu),
        .dbg_exmem_zero   (dbg_exmem_zero),
        .dbg_exmem_target (dbg_exmem_target),
        .dbg_memwb_ctrl   (dbg_memwb_ctrl),
        .dbg_memwb_wreg   (dbg_memwb_wreg),
        .dbg_wb_value     (dbg_wb_value)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Writeback log, sampled mid-cycle
    logic [4:0]  log_reg [32];
    logic [31:0] log_val [32];
    int          log_n = 0;

    always @(negedge clk) begin
        if (!rst && dbg_memwb_ctrl[1] && dbg_memwb_wreg != 5'd0 && log_n < 32) begin
            log_reg[log_n] = dbg_memwb_wreg;
            log_val[log_n] = dbg_wb_value;
            log_n++;
        end
    end

    task automatic t_reset();
        step(2);
        check("R1 reset pc", dbg_pc, 32'd500);
        check("R1 reset ifid", dbg_ifid_instr, 32'd0);
        check("R1 reset idex ctrl", 32'(dbg_idex_ctrl), 32'd0);
        check("R1 reset exmem ctrl", 32'(dbg_exmem_ctrl), 32'd0);
        check("R1 reset memwb ctrl", 32'(dbg_memwb_ctrl), 32'd0);
    endtask

    task automatic t_load_path();
        step(1); // E1
        check("R2 fetch word0", dbg_ifid_instr, IMG[31:0]);
        check("R2 pc after first edge", dbg_pc, 32'd504);
        check("R2 ifid pc4", dbg_ifid_pc4, 32'd504);
        step(1); // E2
        check("R3 load bundle", 32'(dbg_idex_ctrl), 32'h1A1);
        check("R1 reg1 reset value", dbg_idex_rda, 32'd11);
        check("R4 immediate", dbg_idex_imm, 32'd20);
        step(1); // E3
        check("R4 load address via ALUSrc", dbg_exmem_alu, 32'd31);
        check("R11 exmem groups of load", 32'(dbg_exmem_ctrl), 32'h1A);
        check("R3 rtype bundle", 32'(dbg_idex_ctrl), 32'h10C);
        check("R1 reg2 reset value", dbg_idex_rda, 32'd12);
        check("R1 reg3 reset value", dbg_idex_rdb, 32'd13);
        step(1); // E4
        check("R11 memwb group of load", 32'(dbg_memwb_ctrl), 32'd3);
        check("R7 load dest from rt", 32'(dbg_memwb_wreg), 32'd10);
        check("R6 load word at bits 31:2", dbg_wb_value, 32'd1028);
        check("R5 subtract", dbg_exmem_alu, 32'hFFFF_FFFF);
    endtask

    task automatic t_alu_stream();
        step(1); // E5
        check("R5 and", dbg_exmem_alu, 32'd14);
        step(1); // E6
        check("R5 or", dbg_exmem_alu, 32'd17);
        check("R7 rtype dest from rd", 32'(dbg_memwb_wreg), 32'd12);
        check("R7 alu result written", dbg_wb_value, 32'd14);
        step(1); // E7
        check("R5 add", dbg_exmem_alu, 32'd37);
        check("R7 loaded value readable", dbg_idex_rda, 32'd1028);
        check("R8 r0 source reads zero", dbg_idex_rdb, 32'd0);
        step(2); // E9
        check("R9 same-cycle write visible a", dbg_idex_rda, 32'd37);
        check("R9 same-cycle write visible b", dbg_idex_rdb, 32'd37);
        step(2); // E11
        check("R8 r0 write ignored", dbg_idex_rda, 32'd0);
        check("R2 pc before branch", dbg_pc, 32'd544);
    endtask

    task automatic t_branch();
        step(1); // E12
        check("R3 branch bundle", 32'(dbg_idex_ctrl), 32'h042);
        check("R10 shadow fetch 1", dbg_pc, 32'd548);
        step(1); // E13
        check("R10 zero flag taken", 32'(dbg_exmem_zero), 32'd1);
        check("R10 target", dbg_exmem_target, 32'd560);
        check("R10 shadow fetch 2", dbg_pc, 32'd552);
        step(1); // E14
        check("R10 pc redirected", dbg_pc, 32'd560);
        check("R10 not-taken zero flag", 32'(dbg_exmem_zero), 32'd0);
        step(1); // E15
        check("R10 not-taken continues", dbg_pc, 32'd564);
    endtask

    task automatic t_writeback_log();
        logic [4:0]  er [13];
        logic [31:0] ev [13];
        er = '{5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15, 5'd16, 5'd18, 5'd17, 5'd22, 5'd23, 5'd21, 5'd19};
        ev = '{32'd1028, 32'hFFFF_FFFF, 32'd14, 32'd17, 32'd37, 32'd1028, 32'd74,
               32'd31, 32'd11, 32'd1, 32'd17, 32'd23, 32'd1024};
        step(17); // E32
        check("R2 fetch beyond image is zero", dbg_ifid_instr, 32'd0);
        check("R10 writeback count (skipped slot absent)", 32'(log_n), 32'd13);
        for (int k = 0; k < 13; k++) begin
            if (k < log_n) begin
                check($sformatf("R7 writeback %0d reg", k), 32'(log_reg[k]), 32'(er[k]));
                check($sformatf("R7 writeback %0d value", k), log_val[k], ev[k]);
            end
        end
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        @(negedge clk) rst = 1'b0;
        t_load_path();
        t_alu_stream();
        t_branch();
        t_writeback_log();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule